// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a combinational datapath that produces one W-bit result per cycle from two operands. A four-bit select picks the operation. Its upper two bits choose among four groups: arithmetic, bitwise logic, right shift and left shift. Its lower two bits refine the choice within the arithmetic and logic groups. The carry input is part of the opcode for arithmetic work. It turns transfer into increment, add into add-plus-one, subtract-with-borrow into true subtract, and decrement into transfer.

The arithmetic group feeds A and a selected second operand into one ripple-carry adder. The selected operand is zero, B, the complement of B, or all ones. The logic group works bit by bit on A and B. The shifters move A by one position. The bit that fills the vacated end of a right shift is zero for a logical shift, or the sign bit of A when the arithmetic-shift input is high. A left shift always fills the low end with zero. An optional output stage registers the result and the carry so that both appear one clock after the inputs.

Top module: `alsu_top`

## Requirements
- R1: With sel=4'b0000, F equals A when carry_in is 0 and equals A+1 modulo 2^W when carry_in is 1.
- R2: With sel=4'b0001, F equals A+B when carry_in is 0 and A+B+1 when carry_in is 1, modulo 2^W.
- R3: With sel=4'b0010, F equals A plus the bitwise complement of B, plus carry_in, modulo 2^W. With carry_in=1 this is A-B.
- R4: With sel=4'b0011, F equals A-1 modulo 2^W when carry_in is 0, and equals A when carry_in is 1.
- R5: With sel[3:2]=2'b01, F is A&B, A|B, A^B or ~A for sel[1:0] = 00, 01, 10 or 11 respectively. carry_in has no effect on the result.
- R6: With sel[3:2]=2'b10, F[i]=A[i+1] for i<W-1. F[W-1] is 0 when shr_sign is 0 and A[W-1] when shr_sign is 1. sel[1:0] and carry_in have no effect.
- R7: With sel[3:2]=2'b11, F[i]=A[i-1] for i>0 and F[0]=0. sel[1:0], carry_in and shr_sign have no effect.
- R8: carry_out is the adder's carry out of bit W-1 when sel[3:2]=2'b00, and 0 for every other group.
- R9: With the output register present (OUT_REG=1), F and carry_out reflect the inputs sampled at the previous rising clock edge. While reset is asserted, both read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 4 | Operation select: [3:2] group, [1:0] sub-operation |
| carry_in | input | 1 | Carry input to the adder |
| shr_sign | input | 1 | 1 makes a right shift replicate the sign bit |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| f | output | WIDTH | Result |
| carry_out | output | 1 | Adder carry for arithmetic operations, else 0 |

## Verification
The bound checker watches the following on every clock: reset clearing, carry_out staying low outside the arithmetic group, the left-shift and right-shift fill bits, complement of A, plain addition, and transfer of A, each one cycle after the inputs. The subtract, decrement and increment results, and the fact that ignored select bits and carry have no effect, are shown only by the bench. The bench sweeps every select, carry and mode value over all 4-bit operand pairs and adds random vectors and a reset re-entry.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_SHR   = 2'b10,
    GRP_SHL   = 2'b11
  } alsu_grp_e;

  typedef enum logic [1:0] {
    YSEL_ZERO = 2'b00,
    YSEL_B    = 2'b01,
    YSEL_NB   = 2'b10,
    YSEL_ONES = 2'b11
  } alsu_ysel_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } alsu_lop_e;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       ysel,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import alsu_pkg::*;

  logic [WIDTH-1:0] y;
  logic [WIDTH:0]   chain;

  assign chain[0] = cin;

  // per-bit operand multiplexer followed by one full adder per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (alsu_ysel_e'(ysel))
        YSEL_ZERO: y[i] = 1'b0;
        YSEL_B:    y[i] = b[i];
        YSEL_NB:   y[i] = ~b[i];
        default:   y[i] = 1'b1;
      endcase
    end

    assign sum[i]     = a[i] ^ y[i] ^ chain[i];
    assign chain[i+1] = (a[i] & y[i]) | (chain[i] & (a[i] ^ y[i]));
  end

  assign cout = chain[WIDTH];

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       op,
  output logic [WIDTH-1:0] res
);
  import alsu_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (alsu_lop_e'(op))
        LOP_AND: res[i] = a[i] & b[i];
        LOP_OR:  res[i] = a[i] | b[i];
        LOP_XOR: res[i] = a[i] ^ b[i];
        default: res[i] = ~a[i];
      endcase
    end
  end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic             sign_fill,
  output logic [WIDTH-1:0] right,
  output logic [WIDTH-1:0] left
);
  logic fill_hi;
  logic fill_lo;

  assign fill_hi = sign_fill & a[WIDTH-1];
  assign fill_lo = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign right[i] = fill_hi;
    end else begin : g_mid_r
      assign right[i] = a[i+1];
    end

    if (i == 0) begin : g_bot
      assign left[i] = fill_lo;
    end else begin : g_mid_l
      assign left[i] = a[i-1];
    end
  end

endmodule

// File: rtl/alsu_top.sv
module alsu_top #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       sel,
  input  logic             carry_in,
  input  logic             shr_sign,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] f,
  output logic             carry_out
);
  import alsu_pkg::*;

  logic [WIDTH-1:0] arith_sum;
  logic             arith_cout;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] shr_res;
  logic [WIDTH-1:0] shl_res;
  logic [WIDTH-1:0] f_next;
  logic             cout_next;
  logic             rst_core_n;

  alsu_arith #(.WIDTH(WIDTH)) u_arith (
    .a    (a),
    .b    (b),
    .ysel (sel[1:0]),
    .cin  (carry_in),
    .sum  (arith_sum),
    .cout (arith_cout)
  );

  alsu_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (a),
    .b   (b),
    .op  (sel[1:0]),
    .res (logic_res)
  );

  alsu_shift #(.WIDTH(WIDTH)) u_shift (
    .a         (a),
    .sign_fill (shr_sign),
    .right     (shr_res),
    .left      (shl_res)
  );

  // result selection by operation group
  always_comb begin
    cout_next = 1'b0;
    unique case (alsu_grp_e'(sel[3:2]))
      GRP_ARITH: begin
        f_next    = arith_sum;
        cout_next = arith_cout;
      end
      GRP_LOGIC: f_next = logic_res;
      GRP_SHR:   f_next = shr_res;
      default:   f_next = shl_res;
    endcase
  end

  if (OUT_REG) begin : g_reg
    logic [1:0]       rst_pipe;
    logic [WIDTH-1:0] f_q;
    logic             cout_q;

    // asynchronous assertion, synchronous release
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_pipe <= 2'b00;
      else        rst_pipe <= {rst_pipe[0], 1'b1};
    end

    assign rst_core_n = rst_pipe[1];

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) begin
        f_q    <= '0;
        cout_q <= 1'b0;
      end else begin
        f_q    <= f_next;
        cout_q <= cout_next;
      end
    end

    assign f         = f_q;
    assign carry_out = cout_q;
  end else begin : g_comb
    assign rst_core_n = rst_n;
    assign f          = f_next;
    assign carry_out  = cout_next;
  end

endmodule

// File: rtl/alsu_checker.sv
module alsu_checker #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic [3:0]       sel,
  input logic             carry_in,
  input logic             shr_sign,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] f,
  input logic             carry_out
);

  logic primed;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) primed <= 1'b0;
    else             primed <= 1'b1;
  end

  if (OUT_REG) begin : g_chk
    assert_reset_clear_R9: assert property (@(posedge clk)
      !rst_core_n |-> (f == '0 && !carry_out));

    assert_no_carry_outside_arith_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
      (primed && $past(sel[3:2]) != 2'b00) |-> !carry_out);

    assert_shl_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
      (primed && $past(sel[3:2]) == 2'b11) |-> f == {$past(a[WIDTH-2:0]), 1'b0});

    assert_shr_fill_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
      (primed && $past(sel[3:2]) == 2'b10) |->
        (f[WIDTH-1] == ($past(shr_sign) & $past(a[WIDTH-1])) && f[WIDTH-2:0] == $past(a[WIDTH-1:1])));

    assert_complement_a_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
      (primed && $past(sel) == 4'b0111) |-> f == ~$past(a));

    assert_plain_add_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
      (primed && $past(sel) == 4'b0001 && !$past(carry_in)) |->
        f == WIDTH'($past(a) + $past(b)));

    assert_transfer_a_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
      (primed && $past(sel) == 4'b0000 && !$past(carry_in)) |-> f == $past(a));
  end

endmodule

bind alsu_top alsu_checker #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .sel        (sel),
  .carry_in   (carry_in),
  .shr_sign   (shr_sign),
  .a          (a),
  .b          (b),
  .f          (f),
  .carry_out  (carry_out)
);

// File: tb/alsu_top_test.sv
module alsu_top_test;
  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic [3:0]   sel;
  logic         carry_in;
  logic         shr_sign;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [W-1:0] f;
  logic         carry_out;

  int checks;
  int fails;
  bit done;

  alsu_top #(.WIDTH(W), .OUT_REG(1'b1)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .carry_in  (carry_in),
    .shr_sign  (shr_sign),
    .a         (a),
    .b         (b),
    .f         (f),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected {carry, result} from the requirements
  function automatic logic [W:0] model(input logic [3:0] s, input logic ci,
                                       input logic sg, input logic [W-1:0] x,
                                       input logic [W-1:0] y);
    logic [W-1:0] opnd;
    logic [W:0]   total;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: opnd = '0;
          2'b01: opnd = y;
          2'b10: opnd = ~y;
          default: opnd = '1;
        endcase
        total = {1'b0, x} + {1'b0, opnd} + {{W{1'b0}}, ci};
        return total;
      end
      2'b01: begin
        case (s[1:0])
          2'b00: return {1'b0, x & y};
          2'b01: return {1'b0, x | y};
          2'b10: return {1'b0, x ^ y};
          default: return {1'b0, ~x};
        endcase
      end
      2'b10: return {1'b0, (sg ? x[W-1] : 1'b0), x[W-1:1]};
      default: return {1'b0, x[W-2:0], 1'b0};
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: return "R1";
          2'b01: return "R2";
          2'b10: return "R3";
          default: return "R4";
        endcase
      end
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (sel=%b ci=%b sg=%b a=%h b=%h)",
               req, act, exp, sel, carry_in, shr_sign, a, b);
    end
  endtask

  // drive at a falling edge, capture at the rising edge, sample at the next falling edge
  task automatic apply(input logic [3:0] s, input logic ci, input logic sg,
                       input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] exp;
    sel = s; carry_in = ci; shr_sign = sg; a = x; b = y;
    exp = model(s, ci, sg, x, y);
    @(posedge clk);
    @(negedge clk);
    check({req_of(s), "+R9"}, f, exp[W-1:0]);
    check("R8", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, exp[W]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset f", f, '0);
    check("R9 reset carry", {{(W-1){1'b0}}, carry_out}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; sel = '0; carry_in = 1'b0; shr_sign = 1'b0; a = '1; b = '1;
    void'($urandom(32'h1A5E_0C0D));
    repeat (3) @(negedge clk);
    check("R9 reset f", f, '0);
    check("R9 reset carry", {{(W-1){1'b0}}, carry_out}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed corners: wrap on increment, borrow-free subtract, decrement of zero, sign fill
    apply(4'b0000, 1'b1, 1'b0, 4'hF, 4'h0);  // R1 wrap, carry 1
    apply(4'b0010, 1'b1, 1'b0, 4'h3, 4'h3);  // R3 A-A=0, carry 1
    apply(4'b0011, 1'b0, 1'b0, 4'h0, 4'h0);  // R4 0-1=F, carry 0
    apply(4'b1000, 1'b0, 1'b1, 4'h9, 4'h0);  // R6 arithmetic
    apply(4'b1100, 1'b1, 1'b1, 4'h9, 4'hF);  // R7 zero fill

    // exhaustive sweep at 4 bits
    for (int s = 0; s < 16; s++)
      for (int ci = 0; ci < 2; ci++)
        for (int sg = 0; sg < 2; sg++)
          for (int x = 0; x < (1 << W); x++)
            for (int y = 0; y < (1 << W); y++)
              apply(4'(s), 1'(ci), 1'(sg), W'(x), W'(y));

    do_reset();

    for (int n = 0; n < 2000; n++)
      apply(4'($urandom), 1'($urandom), 1'($urandom), W'($urandom), W'($urandom));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule